// File: doc/BRIEF.md
# Serial Management Slave with Preamble Suppression

This block is the device-side end of a two-wire serial management bus. It runs directly on the management clock and samples the bidirectional data line on every rising clock edge. It recognises clause-22 style frames that carry its own 5-bit device address. A write frame produces a one-cycle write strobe that carries the register address and the 16-bit data word. A read frame raises a one-cycle read request toward the register file. The block then takes the bus for the second turnaround bit and shifts the returned word out. Bus output and output-enable are registered, so they change just after a rising edge, and the master samples them on the following rising edge.

After a reset, and after a soft reset, the block stays deaf until it has seen 32 consecutive one bits of preamble. Once it has locked, it accepts frames that begin after a single idle one bit, with no preamble. Because it accepts such frames, it reports preamble suppression: on any read of status register 01h it forces bit 6 of the returned word to one. The other bits come unchanged from the register read port. Frames for another device address, and frames with an opcode that is neither read nor write, are followed bit by bit to their end. They cause no register access and no bus drive.

Top module: `mgmt_serial_slave`

## Requirements
- R1: A frame is decoded from the bits sampled on rising edges in this order: a 0 then a 1 (start), 2 opcode bits, 5 device-address bits, 5 register-address bits, 2 turnaround bits, then 16 data bits. Every field is sent most significant bit first.
- R2: For a matching frame with opcode 0 then 1 (write), `wr_en` is high for exactly one cycle after the edge that samples the last data bit. During that cycle `reg_addr` and `wr_data` carry the frame's fields. `mdio_oe` stays low for the whole write frame.
- R3: For a matching frame with opcode 1 then 0 (read), `rd_en` is high for exactly one cycle after the edge that samples the last register-address bit, with `reg_addr` valid. `mdio_oe` is low in the first turnaround bit period. In the second turnaround bit period the block drives 0. It then drives the 16 bits of `rd_data`, most significant first, each changing after a rising edge. `mdio_oe` falls after the edge that ends the last data bit period, so it is high for 17 bit periods in all.
- R4: A frame whose device address differs from `phy_addr` causes no strobe and no bus drive. It is tracked to its end, so a matching frame that follows it after a single idle bit is accepted.
- R5: After `rst_n` is released, frames are ignored until 32 consecutive one bits have been sampled. A frame that follows only 31 ones causes no strobe and no drive.
- R6: Once locked, the block accepts a frame whose start follows a single sampled idle one bit, with no preamble.
- R7: A cycle with `soft_rst` high ends any frame in progress and clears the lock, so frames are again ignored until 32 consecutive ones have been seen.
- R8: On a read of register address 01h, bit 6 of the driven word is 1 whatever `rd_data` bit 6 holds. All other bits, and all bits of reads at other addresses, equal `rd_data`.
- R9: A matching frame with opcode 0 0 or 1 1 causes no strobe and no bus drive.
- R10: While `rst_n` is low and after it is released, `mdio_oe`, `rd_en` and `wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mdc | input | 1 | Management clock; every register of the block runs on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_rst | input | 1 | Synchronous soft reset; ends a frame in progress and re-arms the preamble requirement |
| phy_addr | input | 5 | Device address this slave answers to |
| mdio_in | input | 1 | Resolved level of the bidirectional data line |
| mdio_out | output | 1 | Value driven onto the data line while `mdio_oe` is high |
| mdio_oe | output | 1 | Output enable for the data line |
| reg_addr | output | 5 | Register address of the last accepted read or write frame |
| rd_en | output | 1 | One-cycle read request to the register file |
| rd_data | input | 16 | Register word returned; sampled one cycle after `rd_en` |
| wr_en | output | 1 | One-cycle write strobe |
| wr_data | output | 16 | Write data, valid while `wr_en` is high |

## Verification
Write and read frames are run with asymmetric data words, such as A5C3, 8001, C35A and FFFF, and with the extreme register address 1Fh. A swapped field, a reversed bit order or a shift of one bit period therefore shows up as a wrong word. Lock behaviour is tried with 31 ones followed by a frame, then with exactly 32 ones, and again after a soft reset. These cases tell an off-by-one preamble count and a lock that a soft reset fails to clear from correct behaviour. Reads at address 01h with bit 6 both clear and set, and a read at another address, separate a correct status override from one that is missing or applied too widely. Reads and writes to another device address, and the two unused opcodes, are each followed by a matching frame after one idle bit. This tells a block that merely stays quiet apart from one that also keeps its frame count through the foreign frame.

// File: rtl/mss_pkg.sv
// Package: shared types and fixed protocol codes for the serial management
// slave. Assumes clause-22 framing with a 2-bit start and 2-bit opcode.
package mss_pkg;

    // Frame decoder position within a frame
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_HDR   = 2'd2,
        ST_BODY  = 2'd3
    } mss_state_e;

    // What the body of the current frame means for this slave
    typedef enum logic [1:0] {
        KIND_SKIP = 2'd0,
        KIND_RD   = 2'd1,
        KIND_WR   = 2'd2
    } mss_kind_e;

    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam int         START_W   = 2;
    localparam int         OPC_W     = 2;
    localparam int         TURN_W    = 2;

endpackage

// File: rtl/mss_preamble_lock.sv
// Module: preamble lock tracker.
// Counts consecutive one bits on the data line and sets a sticky lock flag
// once PRE_LEN of them have been sampled. A zero restarts the count. Reset
// and soft reset clear the lock. Assumes PRE_LEN >= 2.
module mss_preamble_lock #(
    parameter int PRE_LEN = 32
) (
    input  logic mdc,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic mdio_in,
    output logic armed
);
    localparam int CNT_W = $clog2(PRE_LEN);

    logic [CNT_W-1:0] ones_cnt;

    // Count consecutive ones and latch the lock on the last required one
    always_ff @(posedge mdc) begin
        if (!rst_n || soft_rst) begin
            ones_cnt <= '0;
            armed    <= 1'b0;
        end else if (!mdio_in) begin
            ones_cnt <= '0;
        end else if (!armed) begin
            if (ones_cnt == CNT_W'(PRE_LEN - 1)) begin
                armed <= 1'b1;
            end else begin
                ones_cnt <= ones_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/mss_frame_fsm.sv
// Module: frame decoder.
// Waits for an idle one followed by a start pair while locked, shifts in the
// opcode and both addresses, classifies the frame and then counts the
// turnaround and data bits so the frame is followed to its end whatever its
// kind. Issues the read request on the edge that completes the header.
module mss_frame_fsm
    import mss_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int HDR_BITS = 12,
    parameter int BODY_BITS = 18,
    parameter int CNT_W    = 5
) (
    input  logic              mdc,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              armed,
    input  logic              mdio_in,
    input  logic [ADDR_W-1:0] phy_addr,
    output logic              body_act,
    output logic [CNT_W-1:0]  body_cnt,
    output mss_kind_e         kind,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              rd_en
);
    mss_state_e           state;
    logic                 idle_seen;
    logic [CNT_W-1:0]     bit_cnt;
    logic [HDR_BITS-2:0]  hdr_sh;
    logic [HDR_BITS-1:0]  hdr_full;
    logic [OPC_W-1:0]     hdr_opc;
    logic [ADDR_W-1:0]    hdr_phy;
    logic [ADDR_W-1:0]    hdr_reg;
    logic                 hdr_match;

    // Split the header including the bit being sampled now
    always_comb begin
        hdr_full  = {hdr_sh, mdio_in};
        hdr_opc   = hdr_full[HDR_BITS-1 -: OPC_W];
        hdr_phy   = hdr_full[2*ADDR_W-1 -: ADDR_W];
        hdr_reg   = hdr_full[ADDR_W-1:0];
        hdr_match = (hdr_phy == phy_addr);
    end

    // Frame sequencing: idle, start, header shift, body count
    always_ff @(posedge mdc) begin
        if (!rst_n || soft_rst) begin
            state     <= ST_IDLE;
            idle_seen <= 1'b0;
            bit_cnt   <= '0;
            hdr_sh    <= '0;
            kind      <= KIND_SKIP;
            reg_addr  <= '0;
            rd_en     <= 1'b0;
        end else begin
            rd_en <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (mdio_in) begin
                        idle_seen <= 1'b1;
                    end else begin
                        idle_seen <= 1'b0;
                        if (armed && idle_seen) begin
                            state <= ST_START;
                        end
                    end
                end
                ST_START: begin
                    bit_cnt <= '0;
                    state   <= mdio_in ? ST_HDR : ST_IDLE;
                end
                ST_HDR: begin
                    hdr_sh <= hdr_full[HDR_BITS-2:0];
                    if (bit_cnt == CNT_W'(HDR_BITS - 1)) begin
                        state   <= ST_BODY;
                        bit_cnt <= '0;
                        kind    <= KIND_SKIP;
                        if (hdr_match && hdr_opc == OPC_READ) begin
                            kind     <= KIND_RD;
                            reg_addr <= hdr_reg;
                            rd_en    <= 1'b1;
                        end else if (hdr_match && hdr_opc == OPC_WRITE) begin
                            kind     <= KIND_WR;
                            reg_addr <= hdr_reg;
                        end
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                default: begin
                    if (bit_cnt == CNT_W'(BODY_BITS - 1)) begin
                        state   <= ST_IDLE;
                        bit_cnt <= '0;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    // Body position is exposed for the read driver and write capture
    assign body_act = (state == ST_BODY);
    assign body_cnt = bit_cnt;

endmodule

// File: rtl/mss_read_drive.sv
// Module: read data driver.
// During the body of a read frame: releases the line for the first
// turnaround bit, drives 0 for the second, then drives the captured word
// most significant bit first and releases after the last bit. Assumes the
// register file presents rd_data in the cycle after the read request.
module mss_read_drive
    import mss_pkg::*;
#(
    parameter int ADDR_W      = 5,
    parameter int DATA_W      = 16,
    parameter int BODY_BITS   = 18,
    parameter int CNT_W       = 5,
    parameter int STATUS_ADDR = 1,
    parameter int SUPPR_BIT   = 6
) (
    input  logic              mdc,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              body_act,
    input  logic [CNT_W-1:0]  body_cnt,
    input  mss_kind_e         kind,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              mdio_out,
    output logic              mdio_oe
);
    logic [DATA_W-1:0] word_in;
    logic [DATA_W-1:0] out_sh;
    logic              rd_body;

    // Status override: force the suppression-capable bit on the status read
    generate
        if (SUPPR_BIT < DATA_W) begin : g_status_patch
            always_comb begin
                word_in = rd_data;
                if (reg_addr == ADDR_W'(STATUS_ADDR)) begin
                    word_in[SUPPR_BIT] = 1'b1;
                end
            end
        end else begin : g_no_patch
            always_comb word_in = rd_data;
        end
    endgenerate

    assign rd_body = body_act && (kind == KIND_RD);

    // Turnaround and data shifting onto the line
    always_ff @(posedge mdc) begin
        if (!rst_n || soft_rst) begin
            out_sh   <= '0;
            mdio_out <= 1'b0;
            mdio_oe  <= 1'b0;
        end else if (rd_body) begin
            if (body_cnt == '0) begin
                out_sh   <= word_in;
                mdio_out <= 1'b0;
                mdio_oe  <= 1'b1;
            end else if (body_cnt == CNT_W'(BODY_BITS - 1)) begin
                mdio_out <= 1'b0;
                mdio_oe  <= 1'b0;
            end else begin
                mdio_out <= out_sh[DATA_W-1];
                out_sh   <= {out_sh[DATA_W-2:0], 1'b0};
            end
        end
    end

endmodule

// File: rtl/mss_write_capture.sv
// Module: write data capture.
// During the body of a write frame, shifts in the data bits that follow the
// two turnaround bits and pulses the write strobe on the edge that samples
// the last one. Turnaround bit values are not checked.
module mss_write_capture
    import mss_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int BODY_BITS = 18,
    parameter int CNT_W     = 5
) (
    input  logic              mdc,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              body_act,
    input  logic [CNT_W-1:0]  body_cnt,
    input  mss_kind_e         kind,
    input  logic              mdio_in,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_en
);
    logic wr_body;

    assign wr_body = body_act && (kind == KIND_WR);

    // Data shift-in and single-cycle strobe
    always_ff @(posedge mdc) begin
        if (!rst_n || soft_rst) begin
            wr_data <= '0;
            wr_en   <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (wr_body && body_cnt >= CNT_W'(TURN_W)) begin
                wr_data <= {wr_data[DATA_W-2:0], mdio_in};
                wr_en   <= (body_cnt == CNT_W'(BODY_BITS - 1));
            end
        end
    end

endmodule

// File: rtl/mgmt_serial_slave.sv
// Module: serial management slave, top level.
// Joins the preamble lock, frame decoder, read driver and write capture.
// Runs entirely on the management clock, which the master keeps running.
// The data line is split into a resolved input and an output with enable.
module mgmt_serial_slave
    import mss_pkg::*;
#(
    parameter int ADDR_W      = 5,
    parameter int DATA_W      = 16,
    parameter int PRE_LEN     = 32,
    parameter int STATUS_ADDR = 1,
    parameter int SUPPR_BIT   = 6
) (
    input  logic              mdc,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic              mdio_in,
    output logic              mdio_out,
    output logic              mdio_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              rd_en,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data
);
    localparam int HDR_BITS  = OPC_W + 2 * ADDR_W;
    localparam int BODY_BITS = TURN_W + DATA_W;
    localparam int MAX_BITS  = (HDR_BITS > BODY_BITS) ? HDR_BITS : BODY_BITS;
    localparam int CNT_W     = $clog2(MAX_BITS);

    logic             lock_armed;
    logic             body_act;
    logic [CNT_W-1:0] body_cnt;
    mss_kind_e        kind;

    mss_preamble_lock #(
        .PRE_LEN (PRE_LEN)
    ) u_lock (
        .mdc      (mdc),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .mdio_in  (mdio_in),
        .armed    (lock_armed)
    );

    mss_frame_fsm #(
        .ADDR_W    (ADDR_W),
        .HDR_BITS  (HDR_BITS),
        .BODY_BITS (BODY_BITS),
        .CNT_W     (CNT_W)
    ) u_fsm (
        .mdc      (mdc),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .armed    (lock_armed),
        .mdio_in  (mdio_in),
        .phy_addr (phy_addr),
        .body_act (body_act),
        .body_cnt (body_cnt),
        .kind     (kind),
        .reg_addr (reg_addr),
        .rd_en    (rd_en)
    );

    mss_read_drive #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .BODY_BITS   (BODY_BITS),
        .CNT_W       (CNT_W),
        .STATUS_ADDR (STATUS_ADDR),
        .SUPPR_BIT   (SUPPR_BIT)
    ) u_rd (
        .mdc      (mdc),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .body_act (body_act),
        .body_cnt (body_cnt),
        .kind     (kind),
        .reg_addr (reg_addr),
        .rd_data  (rd_data),
        .mdio_out (mdio_out),
        .mdio_oe  (mdio_oe)
    );

    mss_write_capture #(
        .DATA_W    (DATA_W),
        .BODY_BITS (BODY_BITS),
        .CNT_W     (CNT_W)
    ) u_wr (
        .mdc      (mdc),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .body_act (body_act),
        .body_cnt (body_cnt),
        .kind     (kind),
        .mdio_in  (mdio_in),
        .wr_data  (wr_data),
        .wr_en    (wr_en)
    );

endmodule

// File: rtl/mss_checker.sv
// Module: protocol checker bound to the slave top. Watches the strobes, the
// line drive and the internal lock flag.
module mss_checker (
    input logic mdc,
    input logic rst_n,
    input logic soft_rst,
    input logic armed,
    input logic rd_en,
    input logic wr_en,
    input logic mdio_oe,
    input logic mdio_out
);
    AST_RESET_QUIET: assert property (@(posedge mdc)
        !rst_n |=> (!mdio_oe && !rd_en && !wr_en)); // R10

    AST_RD_TA_RELEASED: assert property (@(posedge mdc) disable iff (!rst_n)
        rd_en |-> !mdio_oe); // R3

    AST_RD_TA_ZERO: assert property (@(posedge mdc) disable iff (!rst_n || soft_rst)
        rd_en |=> (mdio_oe && !mdio_out)); // R3

    AST_DRIVE_AFTER_REQ: assert property (@(posedge mdc) disable iff (!rst_n)
        $rose(mdio_oe) |-> $past(rd_en)); // R3

    AST_WR_PULSE: assert property (@(posedge mdc) disable iff (!rst_n)
        wr_en |=> !wr_en); // R2

    AST_UNLOCKED_QUIET: assert property (@(posedge mdc) disable iff (!rst_n)
        !armed |-> (!rd_en && !wr_en && !mdio_oe)); // R5

    AST_SOFT_QUIET: assert property (@(posedge mdc) disable iff (!rst_n)
        soft_rst |=> (!mdio_oe && !rd_en && !wr_en && !armed)); // R7

endmodule

bind mgmt_serial_slave mss_checker u_chk (
    .mdc      (mdc),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .armed    (lock_armed),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .mdio_oe  (mdio_oe),
    .mdio_out (mdio_out)
);

// File: tb/mgmt_serial_slave_bench.sv
// Directed bench for the serial management slave: one task per scenario.
module mgmt_serial_slave_bench;
    localparam int CLK_PERIOD = 20;
    localparam logic [4:0] MY_PHY = 5'h0C;
    localparam logic [1:0] OP_RD = 2'b10;
    localparam logic [1:0] OP_WR = 2'b01;

    logic        mdc = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        m_en = 1'b1;
    logic        m_bit = 1'b1;
    logic [15:0] rd_data = 16'h0000;
    logic        mdio_in;
    logic        mdio_out;
    logic        mdio_oe;
    logic [4:0]  reg_addr;
    logic        rd_en;
    logic        wr_en;
    logic [15:0] wr_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // per-frame observations
    int          f_rd_cnt, f_wr_cnt, f_oe_cnt;
    logic        f_rd_hdr, f_oe_hdr, f_ta_ok;
    logic [15:0] f_bits, f_wdata;
    logic [4:0]  f_waddr;

    always #(CLK_PERIOD/2) mdc = ~mdc;

    // line resolution with a pull-up
    assign mdio_in = mdio_oe ? mdio_out : (m_en ? m_bit : 1'b1);

    mgmt_serial_slave u_mgmt_serial_slave (
        .mdc(mdc), .rst_n(rst_n), .soft_rst(soft_rst), .phy_addr(MY_PHY),
        .mdio_in(mdio_in), .mdio_out(mdio_out), .mdio_oe(mdio_oe),
        .reg_addr(reg_addr), .rd_en(rd_en), .rd_data(rd_data),
        .wr_en(wr_en), .wr_data(wr_data)
    );

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // one bit period: drive after falling edge, sample after rising edge
    task automatic tick(input logic en, input logic b);
        @(negedge mdc);
        m_en  = en;
        m_bit = b;
        @(posedge mdc);
        #(CLK_PERIOD/4);
        if (rd_en) f_rd_cnt++;
        if (mdio_oe) f_oe_cnt++;
        if (wr_en) begin
            f_wr_cnt++;
            f_wdata = wr_data;
            f_waddr = reg_addr;
        end
    endtask

    task automatic idle_bits(input int n);
        for (int i = 0; i < n; i++) tick(1'b1, 1'b1);
    endtask

    // full frame; master_body=1 drives turnaround 1,0 and data, else releases
    task automatic run_frame(input int n_idle, input logic [1:0] op,
                             input logic [4:0] phy, input logic [4:0] ra,
                             input logic [15:0] wd, input logic master_body);
        logic [11:0] hdr;
        idle_bits(n_idle);
        f_rd_cnt = 0; f_wr_cnt = 0; f_oe_cnt = 0;
        f_ta_ok = 0; f_bits = '0; f_wdata = '0; f_waddr = '0;
        hdr = {op, phy, ra};
        tick(1'b1, 1'b0);
        tick(1'b1, 1'b1);
        for (int i = 11; i >= 0; i--) tick(1'b1, hdr[i]);
        f_rd_hdr = rd_en;
        f_oe_hdr = mdio_oe;
        for (int t = 1; t <= 18; t++) begin
            if (master_body)
                tick(1'b1, (t == 1) ? 1'b1 : (t == 2) ? 1'b0 : wd[18-t]);
            else
                tick(1'b0, 1'b1);
            if (t == 1) f_ta_ok = mdio_oe && !mdio_out;
            if (t >= 2 && t <= 17) f_bits = {f_bits[14:0], mdio_out};
        end
    endtask

    task automatic expect_silent(input string req);
        check(req, "write strobes", f_wr_cnt, 0);
        check(req, "read requests", f_rd_cnt, 0);
        check(req, "drive periods", f_oe_cnt, 0);
    endtask

    task automatic expect_write(input string req, input logic [4:0] ra,
                                input logic [15:0] wd);
        check(req, "write strobe count", f_wr_cnt, 1);
        check(req, "write address", f_waddr, ra);
        check(req, "write data", f_wdata, wd);
        check(req, "no drive in write", f_oe_cnt, 0);
    endtask

    task automatic expect_read(input string req, input logic [15:0] exp);
        check(req, "rd_en after header", f_rd_hdr, 1);
        check(req, "rd_en count", f_rd_cnt, 1);
        check(req, "released in first turnaround", f_oe_hdr, 0);
        check(req, "zero in second turnaround", f_ta_ok, 1);
        check(req, "drive period count", f_oe_cnt, 17);
        check(req, "read word", f_bits, exp);
    endtask

    // R10: reset state
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) tick(1'b1, 1'b1);
        check("R10", "oe in reset", mdio_oe, 0);
        check("R10", "rd_en in reset", rd_en, 0);
        check("R10", "wr_en in reset", wr_en, 0);
        @(negedge mdc);
        rst_n = 1'b1;
        tick(1'b1, 1'b0);
        check("R10", "oe after reset", mdio_oe, 0);
        check("R10", "strobes after reset", {rd_en, wr_en}, 0);
    endtask

    // R5: 31 ones are not enough
    task automatic t_short_preamble();
        run_frame(31, OP_WR, MY_PHY, 5'h03, 16'h1234, 1'b1);
        expect_silent("R5");
    endtask

    // R1 R2 R5: exactly 32 ones lock, then a write is taken
    task automatic t_lock_write();
        run_frame(32, OP_WR, MY_PHY, 5'h05, 16'hA5C3, 1'b1);
        expect_write("R2", 5'h05, 16'hA5C3);
        check("R5", "locked after 32 ones", f_wr_cnt, 1);
        tick(1'b1, 1'b1);
        check("R2", "strobe one cycle", wr_en, 0);
    endtask

    // R3 R6: read with a single idle bit and no preamble
    task automatic t_read_one_idle();
        rd_data = 16'hC35A;
        run_frame(1, OP_RD, MY_PHY, 5'h13, 16'h0000, 1'b0);
        expect_read("R3", 16'hC35A);
        check("R6", "frame after one idle bit", f_rd_cnt, 1);
        check("R3", "read address", reg_addr, 5'h13);
    endtask

    // R8: status register suppression bit
    task automatic t_status_bit();
        rd_data = 16'h0000;
        run_frame(1, OP_RD, MY_PHY, 5'h01, 16'h0000, 1'b0);
        check("R8", "status bit 6 forced", f_bits, 16'h0040);
        rd_data = 16'hFFFF;
        run_frame(1, OP_RD, MY_PHY, 5'h01, 16'h0000, 1'b0);
        check("R8", "status other bits kept", f_bits, 16'hFFFF);
        rd_data = 16'h0000;
        run_frame(1, OP_RD, MY_PHY, 5'h02, 16'h0000, 1'b0);
        check("R8", "other address unpatched", f_bits, 16'h0000);
    endtask

    // R4: foreign address ignored but tracked
    task automatic t_mismatch();
        run_frame(1, OP_WR, 5'h0D, 5'h04, 16'hBEEF, 1'b1);
        expect_silent("R4");
        rd_data = 16'h1111;
        run_frame(1, OP_RD, 5'h00, 5'h04, 16'h0000, 1'b0);
        expect_silent("R4");
        run_frame(1, OP_WR, MY_PHY, 5'h1F, 16'h8001, 1'b1);
        expect_write("R4", 5'h1F, 16'h8001);
    endtask

    // R9: unused opcodes
    task automatic t_bad_opcode();
        run_frame(1, 2'b00, MY_PHY, 5'h06, 16'h5555, 1'b1);
        expect_silent("R9");
        run_frame(1, 2'b11, MY_PHY, 5'h06, 16'hAAAA, 1'b1);
        expect_silent("R9");
        run_frame(1, OP_WR, MY_PHY, 5'h07, 16'hFFFF, 1'b1);
        expect_write("R9", 5'h07, 16'hFFFF);
    endtask

    // R7: soft reset re-arms the preamble requirement
    task automatic t_soft_rearm();
        @(negedge mdc);
        soft_rst = 1'b1;
        @(negedge mdc);
        soft_rst = 1'b0;
        run_frame(1, OP_WR, MY_PHY, 5'h08, 16'h00F0, 1'b1);
        expect_silent("R7");
        run_frame(32, OP_WR, MY_PHY, 5'h09, 16'h3C0F, 1'b1);
        expect_write("R7", 5'h09, 16'h3C0F);
    endtask

    // R1: back-to-back frames with varied fields
    task automatic t_patterns();
        run_frame(1, OP_WR, MY_PHY, 5'h00, 16'h0001, 1'b1);
        expect_write("R1", 5'h00, 16'h0001);
        rd_data = 16'h8000;
        run_frame(1, OP_RD, MY_PHY, 5'h1F, 16'h0000, 1'b0);
        expect_read("R1", 16'h8000);
        check("R1", "read address msb first", reg_addr, 5'h1F);
    endtask

    initial begin
        t_reset();
        t_short_preamble();
        t_lock_write();
        t_read_one_idle();
        t_status_bit();
        t_mismatch();
        t_bad_opcode();
        t_soft_rearm();
        t_patterns();
        idle_bits(2);
        done = 1;
        summary();
        $finish;
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge mdc);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

endmodule